// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block holds the byte count that a host programs before a DMA transfer. The count is 24 bits wide and is written one byte at a time through a small byte-wide register port. Each host write lands in a shadow copy. The counter that the host reads back changes only when a command byte with the DMA flag set is written. A command byte without the flag selects programmed I/O and leaves the counter as it was.

When the surrounding controller asks for a transfer to start, the block loads a working length. This length is the smaller of two values. The first is the counter, where a counter of zero stands for 65536. The second is the remaining byte count, or the command-buffer size while command bytes are being collected. The block then counts one down for every byte the DMA engine reports done. When the working length reaches zero, it raises terminal count, clears the readable counter and gives a one-cycle completion pulse.

Until the host first writes the high count byte after a reset, a read of that byte returns a fixed identification code. This lets software tell which controller is present.

Top module: `xfer_count_unit`

## Requirements
- R1: After reset, `tc`, `xfer_active`, `dma_mode` and `done_pulse` are 0, `work_len` is 0, the readable counter is 0, address 2 reads `CHIP_ID` (default 8'hA2) and address 3 reads 0.
- R2: A host write to address 0, 1 or 2 (low, middle, high count byte) updates only the shadow byte of that significance. The readable counter does not change.
- R3: A host write to address 3 with bit 7 set copies all three shadow bytes into the readable counter and sets `dma_mode`. With bit 7 clear, the counter keeps its value and `dma_mode` is cleared.
- R4: A cycle with `xfer_start` high while `dma_mode` is 1 loads `work_len` with min(E, L) and clears `tc`. E is the counter value, or 65536 when the counter is 0. L is `CMD_BUF_BYTES` (default 16) when `cmd_phase` is 1, and `remaining` otherwise. A start while `dma_mode` is 0 is ignored.
- R5: Each cycle with `byte_done` high while `xfer_active` is 1 lowers `work_len` by one. While the block is idle, `byte_done` leaves `work_len` and `tc` unchanged.
- R6: When the working length runs out, the block does four things in the same cycle: `tc` rises, the readable counter becomes 0, `xfer_active` falls and `done_pulse` is high for exactly one cycle. A start whose computed length is 0 completes at once in the same way.
- R7: A host write to any count byte clears `tc`. If a completion happens in the same cycle, `tc` is set.
- R8: A read of address 2 returns `CHIP_ID` until address 2 has been written at least once since reset. After that it returns the high byte of the readable counter.
- R9: Reset clears the record of the high-byte write, so `CHIP_ID` is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | ADDR_W | Register address: 0..2 count bytes, 3 command |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| xfer_start | input | 1 | Request to start a transfer |
| cmd_phase | input | 1 | Transfer collects command bytes; limit is the command buffer |
| remaining | input | REM_W | Bytes still to be moved for the current request |
| byte_done | input | 1 | One byte moved by the DMA engine |
| dma_mode | output | 1 | Last command selected DMA (1) or programmed I/O (0) |
| xfer_active | output | 1 | Working length is counting |
| work_len | output | 8*CNT_BYTES | Working length left |
| tc | output | 1 | Terminal count |
| done_pulse | output | 1 | One-cycle completion (bus service) pulse |

## Verification
The hardest state to reach is a transfer loaded from a zero counter with a large remaining count. Here the 65536 substitute must win the comparison and then be counted all the way down. The bench programs zero into all three bytes, reloads the counter with a DMA command and starts with 70000 bytes remaining. It then holds `byte_done` high for 65536 cycles and checks every step.

A second long run, from 0x012345, shows that a large non-zero count is not capped. The bench also drives a completion and a count-byte write into the same cycle to pin down which one decides `tc`.

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
  parameter int          CNT_BYTES     = 3,
  parameter int          ADDR_W        = 2,
  parameter int          REM_W         = 17,
  parameter int          CMD_BUF_BYTES = 16,
  parameter int          ZERO_LOAD     = 65536,
  parameter int          DMA_FLAG_BIT  = 7,
  parameter logic [7:0]  CHIP_ID       = 8'hA2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [7:0]              host_wdata,
  output logic [7:0]              host_rdata,
  input  logic                    xfer_start,
  input  logic                    cmd_phase,
  input  logic [REM_W-1:0]        remaining,
  input  logic                    byte_done,
  output logic                    dma_mode,
  output logic                    xfer_active,
  output logic [8*CNT_BYTES-1:0]  work_len,
  output logic                    tc,
  output logic                    done_pulse
);

  localparam int                CNT_W    = 8 * CNT_BYTES;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] HI_ADDR  = ADDR_W'(CNT_BYTES - 1);

  logic [7:0]       shadow_b [CNT_BYTES];
  logic [CNT_W-1:0] shadow;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_len;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] start_len;
  logic             hi_written;
  logic             cmd_wr;
  logic             count_wr;
  logic             load;
  logic             finish;

  assign cmd_wr   = host_wr && (host_addr == CMD_ADDR);
  assign count_wr = host_wr && (int'(host_addr) < CNT_BYTES);
  assign eff_len  = (cnt == '0) ? CNT_W'(ZERO_LOAD) : cnt;
  assign limit    = cmd_phase ? CNT_W'(CMD_BUF_BYTES) : CNT_W'(remaining);
  assign start_len = (eff_len < limit) ? eff_len : limit;
  assign load     = xfer_start && dma_mode;
  assign finish   = load ? (start_len == '0)
                         : (xfer_active && byte_done && work_len == CNT_W'(1));

  for (genvar i = 0; i < CNT_BYTES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow_b[i] <= '0;
      else if (host_wr && host_addr == ADDR_W'(i))
        shadow_b[i] <= host_wdata;
    end
    assign shadow[8*i +: 8] = shadow_b[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      dma_mode   <= 1'b0;
      hi_written <= 1'b0;
    end else begin
      if (finish)
        cnt <= '0;
      else if (cmd_wr && host_wdata[DMA_FLAG_BIT])
        cnt <= shadow;
      if (cmd_wr)
        dma_mode <= host_wdata[DMA_FLAG_BIT];
      if (host_wr && host_addr == HI_ADDR)
        hi_written <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_len    <= '0;
      xfer_active <= 1'b0;
      tc          <= 1'b0;
      done_pulse  <= 1'b0;
    end else begin
      done_pulse <= finish;
      if (finish)
        tc <= 1'b1;
      else if (load || count_wr)
        tc <= 1'b0;
      if (load) begin
        work_len    <= start_len;
        xfer_active <= (start_len != '0);
      end else if (xfer_active && byte_done) begin
        work_len <= work_len - CNT_W'(1);
        if (work_len == CNT_W'(1))
          xfer_active <= 1'b0;
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == HI_ADDR && !hi_written)
      host_rdata = CHIP_ID;
    else if (int'(host_addr) < CNT_BYTES)
      host_rdata = cnt[8*int'(host_addr) +: 8];
  end

endmodule

// File: rtl/xfer_count_unit_chk.sv
module xfer_count_unit_chk #(
  parameter int          CNT_BYTES    = 3,
  parameter int          ADDR_W       = 2,
  parameter int          DMA_FLAG_BIT = 7,
  parameter logic [7:0]  CHIP_ID      = 8'hA2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr,
  input logic [ADDR_W-1:0]      host_addr,
  input logic [7:0]             host_wdata,
  input logic [7:0]             host_rdata,
  input logic                   xfer_start,
  input logic                   byte_done,
  input logic                   xfer_active,
  input logic [8*CNT_BYTES-1:0] work_len,
  input logic                   tc,
  input logic                   done_pulse,
  input logic [8*CNT_BYTES-1:0] cnt,
  input logic [8*CNT_BYTES-1:0] shadow,
  input logic                   hi_written
);
  localparam int                CNT_W    = 8 * CNT_BYTES;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CNT_BYTES);
  localparam logic [ADDR_W-1:0] HI_ADDR  = ADDR_W'(CNT_BYTES - 1);

  a_r3_reload_from_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == CMD_ADDR && host_wdata[DMA_FLAG_BIT])
      |=> (done_pulse || cnt == $past(shadow)));

  a_r3_pio_keeps_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == CMD_ADDR && !host_wdata[DMA_FLAG_BIT] && !xfer_active && !xfer_start)
      |=> (cnt == $past(cnt)));

  a_r4_start_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> !tc);

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && byte_done && !xfer_start && work_len > CNT_W'(1))
      |=> (work_len == $past(work_len) - CNT_W'(1)));

  a_r6_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (tc && cnt == '0 && !xfer_active));

  a_r7_write_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && int'(host_addr) < CNT_BYTES) |=> (!tc || done_pulse));

  a_r8_chip_id_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == HI_ADDR && !hi_written) |-> (host_rdata == CHIP_ID));
endmodule

bind xfer_count_unit xfer_count_unit_chk #(
  .CNT_BYTES(CNT_BYTES), .ADDR_W(ADDR_W), .DMA_FLAG_BIT(DMA_FLAG_BIT), .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_start(xfer_start),
  .byte_done(byte_done), .xfer_active(xfer_active), .work_len(work_len),
  .tc(tc), .done_pulse(done_pulse), .cnt(cnt), .shadow(shadow),
  .hi_written(hi_written)
);

// File: tb/xfer_count_unit_tb.sv
module xfer_count_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ID = 8'hA2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        xfer_start = 1'b0;
  logic        cmd_phase = 1'b0;
  logic [16:0] remaining = '0;
  logic        byte_done = 1'b0;
  logic        dma_mode, xfer_active, tc, done_pulse;
  logic [23:0] work_len;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_count_unit u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_start(xfer_start),
    .cmd_phase(cmd_phase), .remaining(remaining), .byte_done(byte_done),
    .dma_mode(dma_mode), .xfer_active(xfer_active), .work_len(work_len),
    .tc(tc), .done_pulse(done_pulse)
  );

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic rd_count(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd(2'd0, b0); rd(2'd1, b1); rd(2'd2, b2);
    v = {b2, b1, b0};
  endtask

  task automatic program_count(input logic [23:0] c);
    logic [23:0] v;
    wr(2'd0, c[7:0]); wr(2'd1, c[15:8]); wr(2'd2, c[23:16]);
    wr(2'd3, 8'h80);
    rd_count(v);
    chk("R3 reload", v == c && dma_mode, v, c);
  endtask

  task automatic start(input int rem, input logic cmd);
    @(negedge clk);
    xfer_start = 1'b1; remaining = 17'(rem); cmd_phase = cmd;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic run_xfer(input logic [23:0] c, input int rem, input logic cmd);
    int eff, lim, exp_len, bad;
    logic [23:0] v;
    eff = (c == 0) ? 65536 : int'(c);
    lim = cmd ? 16 : rem;
    exp_len = (eff < lim) ? eff : lim;
    program_count(c);
    start(rem, cmd);
    chk("R4 start load", work_len == 24'(exp_len) && tc == (exp_len == 0)
        && xfer_active == (exp_len != 0) && done_pulse == (exp_len == 0),
        work_len, exp_len);
    if (exp_len != 0) begin
      bad = 0;
      byte_done = 1'b1;
      for (int j = 1; j <= exp_len; j++) begin
        @(negedge clk);
        if (work_len != 24'(exp_len - j) || done_pulse != (j == exp_len) || tc != (j == exp_len))
          bad++;
      end
      byte_done = 1'b0;
      chk("R5 count down", bad == 0, bad, 0);
    end
    rd_count(v);
    chk("R6 completion", v == 0 && tc && !xfer_active && work_len == 0, v, 0);
    @(negedge clk);
    chk("R6 single pulse", !done_pulse, done_pulse, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [23:0] v;
    int cnts [5] = '{1, 5, 'h300, 0, 'h12345};
    int rems [4] = '{0, 1, 7, 'h200};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", !tc && !xfer_active && !dma_mode && !done_pulse && work_len == 0,
        {tc, xfer_active, dma_mode, done_pulse}, 0);
    rd(2'd2, b); chk("R1 R8 chip id at reset", b == ID, b, ID);
    rd(2'd0, b); chk("R1 low byte zero", b == 0, b, 0);
    rd(2'd3, b); chk("R1 command reads zero", b == 0, b, 0);

    @(negedge clk); byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    chk("R5 idle byte_done ignored", work_len == 0 && !tc, work_len, 0);

    wr(2'd0, 8'h11); wr(2'd1, 8'h22);
    rd(2'd0, b); chk("R2 shadow low", b == 0, b, 0);
    rd(2'd1, b); chk("R2 shadow mid", b == 0, b, 0);
    rd(2'd2, b); chk("R8 id before high write", b == ID, b, ID);
    wr(2'd2, 8'h33);
    rd(2'd2, b); chk("R8 live high after write", b == 0, b, 0);

    wr(2'd3, 8'h01);
    rd_count(v); chk("R3 pio keeps counter", v == 0 && !dma_mode, v, 0);
    start(5, 1'b0);
    chk("R4 pio start ignored", work_len == 0 && !xfer_active, work_len, 0);
    wr(2'd3, 8'h80);
    rd_count(v); chk("R3 dma reload", v == 24'h332211 && dma_mode, v, 24'h332211);
    wr(2'd3, 8'h02);
    rd_count(v); chk("R3 pio after dma", v == 24'h332211 && !dma_mode, v, 24'h332211);

    foreach (cnts[i])
      foreach (rems[k])
        for (int m = 0; m < 2; m++)
          run_xfer(24'(cnts[i]), rems[k], m[0]);

    chk("R6 tc held after run", tc, tc, 1);
    @(negedge clk); byte_done = 1'b1; @(negedge clk); byte_done = 1'b0;
    chk("R5 idle byte_done keeps tc", tc && work_len == 0, tc, 1);
    wr(2'd1, 8'h07);
    chk("R7 count write clears tc", !tc, tc, 0);

    program_count(24'd1);
    start(9, 1'b0);
    chk("R4 length one", work_len == 1, work_len, 1);
    @(negedge clk);
    byte_done = 1'b1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h05;
    @(negedge clk);
    byte_done = 1'b0; host_wr = 1'b0;
    chk("R7 completion beats write", tc && done_pulse, tc, 1);

    run_xfer(24'd0, 70000, 1'b0);
    run_xfer(24'h012345, 100000, 1'b0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, b); chk("R9 id after reset", b == ID && !tc, b, ID);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule